// File: doc/BRIEF.md
# Per-Bank Row Cache Tracker

This block keeps the controller's view of a multi-bank DRAM in which every bank pairs its sense amplifiers with a separate row cache. For each bank it records three things. The first is whether a row is open, and which one. The second is whether the bank's cache holds a valid row. The third is which row that cache holds. Each command presented on the command port is a row open, a read, a write, a close (precharge) or a policy set. The block answers it one cycle later with a cache hit or miss indication or a protocol error flag.

The cache follows a write loading policy that software selects with a policy-set command. In the transfer policy every write loads the written row into the cache. In the bypass policy a write to an uncached row leaves the cache untouched, so a previously read row stays cached. A write to the row already in the cache refreshes the cache under either policy. Closing a bank does not invalidate its cache. A query port returns the open row and the cached row of any bank.

Top module: `rowcache_tracker`

## Requirements
- R1: After reset every bank is closed, every cache is invalid, the policy is transfer (`policy_nwt`=0), and all response outputs are 0.
- R2: A row-open command (op code 1) to a closed bank opens it on the given row. Banks are independent, and all of them may be open at the same time.
- R3: A row-open command to a bank that is already open pulses `rsp_err_act` in the next cycle and changes no state.
- R4: A read or write to a closed bank pulses `rsp_err_idle` in the next cycle, raises neither hit nor miss, and changes no state.
- R5: A read (op code 2) to an open bank reports `rsp_hit` in the next cycle if the bank's cache is valid and holds the open row, and `rsp_miss` otherwise. The cache then holds the open row and is valid.
- R6: Under the transfer policy, a write (op code 3) to an open bank loads the open row into the cache and reports hit or miss by the same rule as R5.
- R7: Under the bypass policy, a write to an open row that is not cached reports a miss and leaves the cache row and valid bit unchanged. A later read of the cached row therefore hits.
- R8: A write to the row already held in the cache reports a hit and keeps that row cached, under either policy.
- R9: A close command (op code 4) closes the bank and leaves its cache valid and unchanged. A close to an already closed bank raises no error.
- R10: A policy-set command (op code 5) loads `cmd_mode_nwt` into the policy. `policy_nwt` shows the new value from the next cycle, and no other command changes it.
- R11: When `cmd_valid` is 0, or the op code is 0, 6 or 7, no state changes and `rsp_valid` stays 0. Every valid op code 1 to 5 gives `rsp_valid`=1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Op code: 1 open, 2 read, 3 write, 4 close, 5 policy set |
| cmd_bank | input | 2 | Target bank |
| cmd_row | input | 12 | Row address for a row-open command |
| cmd_mode_nwt | input | 1 | Policy value for a policy-set command (1 = bypass) |
| qry_bank | input | 2 | Bank selected for the query outputs |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_hit | output | 1 | Access found its row in the cache |
| rsp_miss | output | 1 | Access did not find its row in the cache |
| rsp_err_act | output | 1 | Row open to an already open bank |
| rsp_err_idle | output | 1 | Access to a closed bank |
| policy_nwt | output | 1 | Current write policy, 1 = bypass |
| bank_open | output | 4 | Per-bank open flag |
| cache_valid | output | 4 | Per-bank cache valid flag |
| qry_open_row | output | 12 | Open row of the queried bank |
| qry_cache_row | output | 12 | Cached row of the queried bank |

## Verification
Hit detection and the policy decision on loading the cache both act on a single write command. A write to the row the cache already holds, issued while the bypass policy is active, makes the coherency update and the bypass rule apply to the same access. The bench provokes this case, then checks that a hit is reported and that the cache still holds the row. It also checks that the bypass rule does not freeze the cache when the written row is already the cached one.

// File: rtl/rct_pkg.sv
package rct_pkg;
   typedef enum logic [2:0] {
      OP_NOP = 3'd0,
      OP_ACT = 3'd1,
      OP_RD  = 3'd2,
      OP_WR  = 3'd3,
      OP_PRE = 3'd4,
      OP_MRS = 3'd5
   } rct_op_e;

   function automatic logic op_known(input logic [2:0] op);
      return (op >= 3'd1) && (op <= 3'd5);
   endfunction
endpackage

// File: rtl/rct_decode.sv
module rct_decode #(
   parameter int NUM_BANKS = 4,
   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [BANK_W-1:0]    cmd_bank,
   output logic [NUM_BANKS-1:0] bank_sel,
   output logic                 mrs_en,
   output logic                 known_cmd
);
   import rct_pkg::*;

   assign known_cmd = cmd_valid && op_known(cmd_op);
   assign mrs_en    = cmd_valid && (cmd_op == OP_MRS);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
      assign bank_sel[b] = known_cmd && (cmd_op != OP_MRS) && (cmd_bank == BANK_W'(b));
   end
endmodule

// File: rtl/rct_policy.sv
module rct_policy (
   input  logic clk,
   input  logic rst_n,
   input  logic set_en,
   input  logic mode_bit,
   output logic policy_nwt
);
   always_ff @(posedge clk) begin
      if (!rst_n)      policy_nwt <= 1'b0;
      else if (set_en) policy_nwt <= mode_bit;
   end

   p_policy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !set_en |=> $stable(policy_nwt));
endmodule

// File: rtl/rct_bank.sv
module rct_bank #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic [2:0]       op,
   input  logic [ROW_W-1:0] row,
   input  logic             policy_nwt,
   output logic             is_open,
   output logic [ROW_W-1:0] open_row,
   output logic             cache_vld,
   output logic [ROW_W-1:0] cache_row,
   output logic             hit,
   output logic             miss,
   output logic             err_act,
   output logic             err_idle
);
   import rct_pkg::*;

   logic is_rd, is_wr, access, match, load, do_act, do_pre;

   assign is_rd    = (op == OP_RD);
   assign is_wr    = (op == OP_WR);
   assign access   = sel && (is_rd || is_wr);
   assign match    = cache_vld && (cache_row == open_row);
   assign do_act   = sel && (op == OP_ACT) && !is_open;
   assign do_pre   = sel && (op == OP_PRE);
   assign err_act  = sel && (op == OP_ACT) && is_open;
   assign err_idle = access && !is_open;
   assign hit      = access && is_open && match;
   assign miss     = access && is_open && !match;
   assign load     = access && is_open && (is_rd || match || !policy_nwt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open   <= 1'b0;
         open_row  <= '0;
         cache_vld <= 1'b0;
         cache_row <= '0;
      end else begin
         if (do_act) begin
            is_open  <= 1'b1;
            open_row <= row;
         end else if (do_pre) begin
            is_open  <= 1'b0;
         end
         if (load) begin
            cache_vld <= 1'b1;
            cache_row <= open_row;
         end
      end
   end

   p_act_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op == OP_ACT && is_open) |=> (is_open && $stable(open_row)));
   p_idle_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !is_open) |=> ($stable(cache_vld) && $stable(cache_row) && !is_open));
   p_read_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && is_rd && is_open) |=> (cache_vld && cache_row == $past(open_row)));
   p_bypass_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && is_wr && is_open && policy_nwt && !(cache_vld && cache_row == open_row))
      |=> ($stable(cache_row) && $stable(cache_vld)));
   p_close_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op == OP_PRE) |=> (!is_open && $stable(cache_vld) && $stable(cache_row)));
endmodule

// File: rtl/rct_resp.sv
module rct_resp #(
   parameter int NUM_BANKS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 known_cmd,
   input  logic [NUM_BANKS-1:0] b_hit,
   input  logic [NUM_BANKS-1:0] b_miss,
   input  logic [NUM_BANKS-1:0] b_err_act,
   input  logic [NUM_BANKS-1:0] b_err_idle,
   output logic                 rsp_valid,
   output logic                 rsp_hit,
   output logic                 rsp_miss,
   output logic                 rsp_err_act,
   output logic                 rsp_err_idle
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_miss     <= 1'b0;
         rsp_err_act  <= 1'b0;
         rsp_err_idle <= 1'b0;
      end else begin
         rsp_valid    <= known_cmd;
         rsp_hit      <= |b_hit;
         rsp_miss     <= |b_miss;
         rsp_err_act  <= |b_err_act;
         rsp_err_idle <= |b_err_idle;
      end
   end

   p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(b_hit | b_miss | b_err_act | b_err_idle));
   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !known_cmd |=> (!rsp_valid && !rsp_hit && !rsp_miss && !rsp_err_act && !rsp_err_idle));
   p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_hit, rsp_miss, rsp_err_act, rsp_err_idle}));
endmodule

// File: rtl/rowcache_tracker.sv
module rowcache_tracker #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic [ROW_W-1:0]     cmd_row,
   input  logic                 cmd_mode_nwt,
   input  logic [BANK_W-1:0]    qry_bank,
   output logic                 rsp_valid,
   output logic                 rsp_hit,
   output logic                 rsp_miss,
   output logic                 rsp_err_act,
   output logic                 rsp_err_idle,
   output logic                 policy_nwt,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic [NUM_BANKS-1:0] cache_valid,
   output logic [ROW_W-1:0]     qry_open_row,
   output logic [ROW_W-1:0]     qry_cache_row
);
   if (NUM_BANKS < 2 || NUM_BANKS != (1 << BANK_W)) begin : g_bad_banks
      $error("rowcache_tracker: NUM_BANKS must be a power of two of at least 2");
   end
   if (ROW_W < 1 || ROW_W > 24) begin : g_bad_row
      $error("rowcache_tracker: ROW_W out of range");
   end

   logic [NUM_BANKS-1:0] bank_sel, b_hit, b_miss, b_err_act, b_err_idle;
   logic                 mrs_en, known_cmd;
   logic [ROW_W-1:0]     open_rows  [NUM_BANKS];
   logic [ROW_W-1:0]     cache_rows [NUM_BANKS];

   rct_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_bank  (cmd_bank),
      .bank_sel  (bank_sel),
      .mrs_en    (mrs_en),
      .known_cmd (known_cmd)
   );

   rct_policy u_pol (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_en     (mrs_en),
      .mode_bit   (cmd_mode_nwt),
      .policy_nwt (policy_nwt)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      rct_bank #(.ROW_W(ROW_W)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .sel        (bank_sel[b]),
         .op         (cmd_op),
         .row        (cmd_row),
         .policy_nwt (policy_nwt),
         .is_open    (bank_open[b]),
         .open_row   (open_rows[b]),
         .cache_vld  (cache_valid[b]),
         .cache_row  (cache_rows[b]),
         .hit        (b_hit[b]),
         .miss       (b_miss[b]),
         .err_act    (b_err_act[b]),
         .err_idle   (b_err_idle[b])
      );
   end

   rct_resp #(.NUM_BANKS(NUM_BANKS)) u_resp (
      .clk          (clk),
      .rst_n        (rst_n),
      .known_cmd    (known_cmd),
      .b_hit        (b_hit),
      .b_miss       (b_miss),
      .b_err_act    (b_err_act),
      .b_err_idle   (b_err_idle),
      .rsp_valid    (rsp_valid),
      .rsp_hit      (rsp_hit),
      .rsp_miss     (rsp_miss),
      .rsp_err_act  (rsp_err_act),
      .rsp_err_idle (rsp_err_idle)
   );

   assign qry_open_row  = open_rows[qry_bank];
   assign qry_cache_row = cache_rows[qry_bank];

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (bank_open == '0 && cache_valid == '0 && !policy_nwt));
endmodule

// File: tb/rowcache_tracker_test.sv
module rowcache_tracker_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [1:0]  cmd_bank = 2'd0;
   logic [11:0] cmd_row = 12'd0;
   logic        cmd_mode_nwt = 1'b0;
   logic [1:0]  qry_bank = 2'd0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_err_act, rsp_err_idle, policy_nwt;
   logic [3:0]  bank_open, cache_valid;
   logic [11:0] qry_open_row, qry_cache_row;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rowcache_tracker uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_mode_nwt(cmd_mode_nwt),
      .qry_bank(qry_bank), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_miss(rsp_miss), .rsp_err_act(rsp_err_act), .rsp_err_idle(rsp_err_idle),
      .policy_nwt(policy_nwt), .bank_open(bank_open), .cache_valid(cache_valid),
      .qry_open_row(qry_open_row), .qry_cache_row(qry_cache_row)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // drive at a falling edge, the design registers at the rising edge,
   // results are sampled at the following falling edge
   task automatic issue(input logic [2:0] op, input logic [1:0] bank,
                        input logic [11:0] row, input logic mode);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank; cmd_row = row; cmd_mode_nwt = mode;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
   endtask

   task automatic check_rsp(input string req, input int v, input int h, input int m,
                            input int ea, input int ei);
      check(req, "rsp_valid", rsp_valid, v);
      check(req, "rsp_hit", rsp_hit, h);
      check(req, "rsp_miss", rsp_miss, m);
      check(req, "rsp_err_act", rsp_err_act, ea);
      check(req, "rsp_err_idle", rsp_err_idle, ei);
   endtask

   task automatic check_bank(input string req, input logic [1:0] b, input int orow,
                             input int crow);
      qry_bank = b;
      #1;
      if (orow >= 0) check(req, "open row", qry_open_row, orow);
      if (crow >= 0) check(req, "cache row", qry_cache_row, crow);
   endtask

   task automatic t_reset();
      check("R1", "bank_open", bank_open, 0);
      check("R1", "cache_valid", cache_valid, 0);
      check("R1", "policy", policy_nwt, 0);
      check_rsp("R1", 0, 0, 0, 0, 0);
   endtask

   task automatic t_open_all();
      issue(3'd1, 2'd0, 12'd5, 1'b0);
      check_rsp("R2", 1, 0, 0, 0, 0);
      issue(3'd1, 2'd1, 12'd7, 1'b0);
      issue(3'd1, 2'd2, 12'd9, 1'b0);
      issue(3'd1, 2'd3, 12'd4095, 1'b0);
      check("R2", "bank_open", bank_open, 4'hF);
      check_bank("R2", 2'd0, 5, -1);
      check_bank("R2", 2'd2, 9, -1);
      check_bank("R2", 2'd3, 4095, -1);
   endtask

   task automatic t_open_conflict();
      issue(3'd1, 2'd0, 12'd6, 1'b0);
      check_rsp("R3", 1, 0, 0, 1, 0);
      check_bank("R3", 2'd0, 5, -1);
      check("R3", "bank_open", bank_open, 4'hF);
   endtask

   task automatic t_read();
      issue(3'd2, 2'd0, 12'd0, 1'b0);
      check_rsp("R5 first read", 1, 0, 1, 0, 0);
      check("R5", "cache_valid", cache_valid, 4'b0001);
      check_bank("R5", 2'd0, -1, 5);
      issue(3'd2, 2'd0, 12'd0, 1'b0);
      check_rsp("R5 second read", 1, 1, 0, 0, 0);
   endtask

   task automatic t_close();
      issue(3'd4, 2'd0, 12'd0, 1'b0);
      check_rsp("R9", 1, 0, 0, 0, 0);
      check("R9", "bank_open", bank_open, 4'b1110);
      check("R9", "cache_valid", cache_valid, 4'b0001);
      check_bank("R9", 2'd0, -1, 5);
      issue(3'd4, 2'd0, 12'd0, 1'b0);
      check_rsp("R9 close closed", 1, 0, 0, 0, 0);
      issue(3'd2, 2'd0, 12'd0, 1'b0);
      check_rsp("R4 read closed", 1, 0, 0, 0, 1);
      issue(3'd3, 2'd0, 12'd0, 1'b0);
      check_rsp("R4 write closed", 1, 0, 0, 0, 1);
      check("R4", "cache_valid", cache_valid, 4'b0001);
      check("R4", "bank_open", bank_open, 4'b1110);
      check_bank("R4", 2'd0, -1, 5);
   endtask

   task automatic t_transfer_write();
      issue(3'd3, 2'd1, 12'd0, 1'b0);
      check_rsp("R6", 1, 0, 1, 0, 0);
      check("R6", "cache_valid", cache_valid, 4'b0011);
      check_bank("R6", 2'd1, -1, 7);
   endtask

   task automatic t_bypass_write();
      issue(3'd5, 2'd0, 12'd0, 1'b1);
      check_rsp("R10", 1, 0, 0, 0, 0);
      check("R10", "policy", policy_nwt, 1);
      issue(3'd1, 2'd0, 12'd8, 1'b0);
      check("R10", "policy after open", policy_nwt, 1);
      issue(3'd3, 2'd0, 12'd0, 1'b0);
      check_rsp("R7 write uncached", 1, 0, 1, 0, 0);
      check_bank("R7", 2'd0, 8, 5);
      check("R7", "cache_valid", cache_valid, 4'b0011);
      // also bypass on a bank whose cache is still invalid
      issue(3'd3, 2'd2, 12'd0, 1'b0);
      check("R7", "cache_valid bank2", cache_valid, 4'b0011);
      issue(3'd4, 2'd0, 12'd0, 1'b0);
      issue(3'd1, 2'd0, 12'd5, 1'b0);
      issue(3'd2, 2'd0, 12'd0, 1'b0);
      check_rsp("R7 read cached row", 1, 1, 0, 0, 0);
   endtask

   task automatic t_write_hit();
      // bypass policy active, bank0 open on row 5 which is cached
      issue(3'd3, 2'd0, 12'd0, 1'b0);
      check_rsp("R8 bypass", 1, 1, 0, 0, 0);
      check_bank("R8", 2'd0, 5, 5);
      check("R8", "cache_valid", cache_valid, 4'b0011);
      issue(3'd5, 2'd0, 12'd0, 1'b0);
      check("R10", "policy back", policy_nwt, 0);
      issue(3'd3, 2'd1, 12'd0, 1'b0);
      check_rsp("R8 transfer", 1, 1, 0, 0, 0);
      check_bank("R8", 2'd1, 7, 7);
   endtask

   task automatic t_ignored();
      issue(3'd6, 2'd2, 12'd1, 1'b1);
      check_rsp("R11 op 6", 0, 0, 0, 0, 0);
      check("R11", "policy", policy_nwt, 0);
      issue(3'd0, 2'd3, 12'd1, 1'b1);
      check_rsp("R11 op 0", 0, 0, 0, 0, 0);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd4; cmd_bank = 2'd2;
      @(negedge clk);
      cmd_op = 3'd0;
      check_rsp("R11 not valid", 0, 0, 0, 0, 0);
      check("R11", "bank_open", bank_open, 4'hF);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 5000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_open_all();
      t_open_conflict();
      t_read();
      t_close();
      t_transfer_write();
      t_bypass_write();
      t_write_hit();
      t_ignored();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule